// File: doc/BRIEF.md
# Video Field Identifier Generator

This block drives the one-bit field identifier that travels alongside a video stream, so downstream logic can tell which field of an interlaced picture each frame carries. It watches a single-cycle start-of-frame strobe and a three-bit mode word. On each strobe it takes a snapshot of the mode word and settles the level that the output holds for the whole frame that follows.

The mode word chooses among three behaviours. Progressive content pins the field at field 0. Interlaced content, generated locally, alternates fields frame by frame. Interlaced pass-through copies the field from an input pin. In every mode a polarity bit sets whether field 0 is shown as a low or a high level. All the pins are plain control levels and strobes. Nothing is carried with a valid/ready handshake, so there is no back-pressure: the strobe is taken on the cycle it is high.

Top module: `fid_gen`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released until the first start-of-frame strobe, `fid_out` is 0.
- R2: `cfg_word` bit 0 selects progressive (0) or interlaced (1). A frame that begins with bit 0 clear carries field 0, whatever bit 2 and `fid_in` are.
- R3: `cfg_word` bit 1 sets polarity. With 0, `fid_out` is low for field 0 and high for field 1. With 1, `fid_out` is high for field 0 and low for field 1.
- R4: With bit 0 set and bit 2 clear (local generation), the first such frame after reset, after a progressive frame or after a pass-through frame carries field 0. Each later consecutive such frame carries the opposite field to the one before.
- R5: With bits 0 and 2 both set (pass-through), a frame carries the field equal to `fid_in` as sampled on its start-of-frame cycle.
- R6: `cfg_word` and `fid_in` are sampled only on the rising clock edge where `sof` is high. `fid_out` changes only in the cycle after such an edge, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sof | input | 1 | Start-of-frame strobe, one cycle high per frame |
| cfg_word | input | 3 | Mode word: bit 0 interlaced, bit 1 polarity, bit 2 pass-through |
| fid_in | input | 1 | Field identifier from upstream, used in pass-through |
| fid_out | output | 1 | Field identifier level for the current frame |

## Verification
The assertions take three things for granted. The strobe is synchronous to `clk` and may arrive on any cycle. `cfg_word` and `fid_in` may be any value on any cycle. Reset is synchronous. The properties compare the held output, the held mode and the field register with the values sampled at the previous strobe edge, so they never rely on the mode word being stable between strobes. The stimulus drives every input just after a falling edge and pulses `sof` for exactly one cycle per frame. Between strobes it deliberately changes `cfg_word` and `fid_in` to show that those changes have no effect.

// File: rtl/fid_pkg.sv
package fid_pkg;

  localparam int unsigned CFG_W      = 3;
  localparam int unsigned BIT_ILACE  = 0;
  localparam int unsigned BIT_POL    = 1;
  localparam int unsigned BIT_PASS   = 2;

  typedef enum logic [1:0] {
    FM_PROG = 2'd0,
    FM_GEN  = 2'd1,
    FM_PASS = 2'd2
  } fmode_t;

  typedef struct packed {
    fmode_t mode;
    logic   pol;
  } fcfg_t;

endpackage

// File: rtl/fid_cfg_decode.sv
module fid_cfg_decode
  import fid_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output fcfg_t            cfg_dec
);

  always_comb begin
    cfg_dec.pol = cfg_word[BIT_POL];
    if (!cfg_word[BIT_ILACE])
      cfg_dec.mode = FM_PROG;
    else if (cfg_word[BIT_PASS])
      cfg_dec.mode = FM_PASS;
    else
      cfg_dec.mode = FM_GEN;
  end

endmodule

// File: rtl/fid_cfg_hold.sv
module fid_cfg_hold
  import fid_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sof,
  input  fcfg_t cfg_dec,
  output fcfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.mode <= FM_PROG;
      cfg_q.pol  <= 1'b0;
    end else if (sof) begin
      cfg_q <= cfg_dec;
    end
  end

  // The held mode only moves on a frame boundary
  assert_mode_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(cfg_q));

endmodule

// File: rtl/fid_field_seq.sv
module fid_field_seq
  import fid_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sof,
  input  fmode_t mode_nx,
  input  logic   fid_in,
  output logic   field_q
);

  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (sof) begin
      unique case (mode_nx)
        FM_GEN: begin
          field_q <= run_q ? ~field_q : 1'b0;
          run_q   <= 1'b1;
        end
        FM_PASS: begin
          field_q <= fid_in;
          run_q   <= 1'b0;
        end
        default: begin
          field_q <= 1'b0;
          run_q   <= 1'b0;
        end
      endcase
    end
  end

  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && mode_nx == FM_GEN && run_q) |=> (field_q != $past(field_q)));

  assert_first_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && mode_nx == FM_GEN && !run_q) |=> !field_q);

  assert_copy_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && mode_nx == FM_PASS) |=> (field_q == $past(fid_in)));

endmodule

// File: rtl/fid_gen.sv
module fid_gen
  import fid_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             fid_in,
  output logic             fid_out
);

  fcfg_t cfg_dec;
  fcfg_t cfg_q;
  logic  field_q;

  fid_cfg_decode u_dec (
    .cfg_word (cfg_word),
    .cfg_dec  (cfg_dec)
  );

  fid_cfg_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .sof     (sof),
    .cfg_dec (cfg_dec),
    .cfg_q   (cfg_q)
  );

  fid_field_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sof     (sof),
    .mode_nx (cfg_dec.mode),
    .fid_in  (fid_in),
    .field_q (field_q)
  );

  assign fid_out = field_q ^ cfg_q.pol;

  assert_out_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(fid_out));

  assert_prog_field0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == FM_PROG) |-> !field_q);

  assert_pol_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == FM_PROG) |-> (fid_out == cfg_q.pol));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (fid_out == 1'b0 || $isunknown(fid_out))
        else $error("fid_out high during reset");
    end
  end

endmodule

// File: tb/sim_fid_gen.sv
module sim_fid_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0;
  logic [2:0] cfg_word = 3'b000;
  logic       fid_in = 1'b0;
  logic       fid_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fid_gen u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (sof),
    .cfg_word (cfg_word),
    .fid_in   (fid_in),
    .fid_out  (fid_out)
  );

  // vector: {cfg_word[2:0], fid_in, expected fid_out}
  localparam int NV = 16;
  localparam logic [4:0] VEC [NV] = '{
    {3'b001, 1'b0, 1'b0},  // R4 first generated frame is field 0
    {3'b001, 1'b1, 1'b1},  // R4 alternates, fid_in ignored
    {3'b001, 1'b0, 1'b0},  // R4
    {3'b011, 1'b0, 1'b0},  // R3 field 1 inverted
    {3'b011, 1'b1, 1'b1},  // R3 field 0 inverted
    {3'b000, 1'b1, 1'b0},  // R2 progressive, polarity 0
    {3'b010, 1'b0, 1'b1},  // R2 R3 progressive, polarity 1
    {3'b001, 1'b0, 1'b0},  // R4 restart after progressive
    {3'b001, 1'b0, 1'b1},  // R4
    {3'b101, 1'b1, 1'b1},  // R5 pass-through copy
    {3'b101, 1'b0, 1'b0},  // R5
    {3'b111, 1'b0, 1'b1},  // R5 R3 inverted copy
    {3'b111, 1'b1, 1'b0},  // R5 R3
    {3'b100, 1'b1, 1'b0},  // R2 pass bit ignored when progressive
    {3'b110, 1'b1, 1'b1},  // R2 R3
    {3'b001, 1'b1, 1'b0}   // R4 restart after pass-through
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: fid_out=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] c, input logic f);
    @(negedge clk);
    cfg_word = c;
    fid_in   = f;
    sof      = 1'b1;
    @(negedge clk);
    sof      = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", fid_out, 1'b0);
    cfg_word = 3'b111;
    fid_in   = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release before sof", fid_out, 1'b0);

    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][4:2], VEC[i][1]);
      check($sformatf("R2-R5 vector %0d", i), fid_out, VEC[i][0]);
    end

    // R6: changes between strobes have no effect
    frame(3'b001, 1'b0);
    check("R4 second generated frame", fid_out, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_word = 3'(k + 2);
      fid_in   = ~fid_in;
      @(negedge clk);
      check("R6 steady between strobes", fid_out, 1'b1);
    end
    cfg_word = 3'b001;
    frame(3'b001, 1'b0);
    check("R6 R4 sequence kept across ignored changes", fid_out, 1'b0);

    // R1: reset in mid-run, then the generator restarts at field 0
    frame(3'b011, 1'b0);
    check("R3 before reset", fid_out, 1'b0);
    frame(3'b001, 1'b0);
    check("R4 before reset", fid_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 mid-run reset", fid_out, 1'b0);
    rst_n = 1'b1;
    frame(3'b001, 1'b1);
    check("R1 R4 field 0 after reset", fid_out, 1'b0);
    frame(3'b001, 1'b0);
    check("R4 field 1 after reset", fid_out, 1'b1);

    // R6: strobe held for back-to-back frames
    @(negedge clk);
    cfg_word = 3'b101;
    fid_in   = 1'b0;
    sof      = 1'b1;
    @(negedge clk);
    check("R5 R6 back-to-back frame 1", fid_out, 1'b0);
    fid_in = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    check("R5 R6 back-to-back frame 2", fid_out, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: finished=%b expected=%b", 1'b0, 1'b1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule